// File: doc/BRIEF.md
# Clock Source Mode Controller

This block picks the operating mode of an on-chip clock generator from a few control fields that software writes. The fields are a 2-bit clock-select, a reference-select bit and a low-power bit. A debug-active input is also taken into account. From the current mode, the block drives four things:

- the enable of the internal reference oscillator;
- the enable of the external reference path;
- the run enable of the frequency-locked loop, together with the loop's reference choice;
- the select of a glitch-free output multiplexer that feeds either the loop output or the internal reference to the chip.

When the loop runs, it is meant to settle at 1024 times its reference. The block models only the loop's enable and its reference choice. The loop oscillator and the reference oscillator are clock inputs.

The mode register runs on a configuration clock, and the mode takes effect one cycle after a legal field combination is presented. Combinations that name no mode are ignored. When debug becomes active while the loop is parked for low power, the block restarts the loop at once.

In external-reference mode, the divided external frequency is checked against the 31.25 kHz to 39.0625 kHz window. The divider code and range bit are used for this check and for nothing else. The output multiplexer uses a two-flop handshake per source. A busy flag reports when a source change is still in flight.

Top module: `clk_mode_ctrl`

## Requirements
- R1: During and after reset, with no legal new combination presented, mode reads 0, the internal reference enable is 1, the external reference enable is 0, the loop enable is 1, the loop-uses-external flag is 0 and the range error is 0.
- R2: Clock-select 2'b00 with reference-select 1 gives mode 0 one clock after it is presented: internal reference on, external reference off, loop on and referenced to the internal clock.
- R3: Clock-select 2'b00 with reference-select 0 gives mode 1 one clock later: external reference on, internal reference off, loop on and referenced to the external clock. The external enable is never high in any other mode.
- R4: Clock-select 2'b01 with reference-select 1 gives mode 2 one clock later when the low-power bit is 0 or debug is active. The internal reference is on, the loop keeps running on the internal reference, and the multiplexer selects the reference.
- R5: Clock-select 2'b01 with reference-select 1, low-power bit 1 and debug inactive gives mode 3. The internal reference is on and the multiplexer selects the reference. The loop enable stays high while busy is high and drops to 0 once busy is low.
- R6: If debug is active while mode is 3 and the fields still request the bypass, the mode becomes 2 and the loop enable is 1 on the next clock.
- R7: Clock-select 2'b10 or 2'b11, or clock-select 2'b01 with reference-select 0, is ignored: mode and all enables keep their previous values.
- R8: The range error is 1, one clock after its inputs are presented, exactly when mode is 1 and EXT_HZ / 2^(div_code + 5*range_hi) lies outside 31250 Hz to 39062.5 Hz. In every other mode it is 0.
- R9: Once busy is low, the output clock toggles with the loop clock in modes 0 and 1 and with the internal reference clock in modes 2 and 3.
- R10: On any change of multiplexer source, busy is high from the clock on which the mode changes until the new source is gated through. At most one source is gated at a time, and no high or low phase of the output clock is shorter than the shortest phase of either source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cfg | input | 1 | Configuration clock for the mode register |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 2 | Clock-select field |
| ref_int | input | 1 | Reference-select: 1 internal, 0 external |
| low_pwr | input | 1 | Low-power request for the bypass mode |
| dbg_on | input | 1 | Debug session active |
| div_code | input | DIV_W | External reference divider exponent |
| range_hi | input | 1 | Adds RANGE_SHIFT to the divider exponent |
| clk_loop | input | 1 | Frequency-locked loop output clock |
| clk_iref | input | 1 | Internal reference clock |
| iref_en | output | 1 | Internal reference enable |
| eref_en | output | 1 | External reference enable |
| loop_en | output | 1 | Loop run enable |
| loop_ref_ext | output | 1 | Loop locks to external reference when 1 |
| range_err | output | 1 | Divided external reference out of window |
| mode | output | 3 | Current mode: 0 int-engaged, 1 ext-engaged, 2 bypass, 3 bypass low-power |
| busy | output | 1 | Output multiplexer switch in progress |
| clk_out | output | 1 | Glitch-free output clock |

## Verification
The field combinations are swept through every legal mode and every ignored encoding. Each step checks the registered mode and the enable set, which separates the two engaged modes (the external path and the loop reference flip) from the two bypass modes (only the loop enable differs).

The low-power bypass is entered twice. One entry comes from bypass, with no switch and an immediate loop stop. The other comes from an engaged mode, where the loop must stay up through the handshake. A third case raises debug while parked.

Divider codes are chosen to land in the frequency window, below it and above it, in both ranges, and once in a non-external mode. The output clock's edge count and minimum phase width are measured across every source switch.

// File: rtl/cms_pkg.sv
`timescale 1ns/1ps
package cms_pkg;

   typedef enum logic [2:0] {
      MODE_INT_ENG = 3'd0,
      MODE_EXT_ENG = 3'd1,
      MODE_BYP_INT = 3'd2,
      MODE_BYP_LP  = 3'd3
   } cms_mode_e;

   typedef struct packed {
      logic iref_on;
      logic eref_on;
      logic loop_run;
      logic loop_ext;
      logic pick_ref;
   } cms_ctl_t;

   // Twice the window edges in Hz, so the half-hertz upper edge stays integral.
   localparam longint unsigned WIN_LO_X2 = 64'd62500;
   localparam longint unsigned WIN_HI_X2 = 64'd78125;

   function automatic cms_ctl_t ctl_of(input cms_mode_e m);
      cms_ctl_t c;
      c = '0;
      case (m)
         MODE_INT_ENG: begin c.iref_on = 1'b1; c.loop_run = 1'b1; end
         MODE_EXT_ENG: begin c.eref_on = 1'b1; c.loop_run = 1'b1; c.loop_ext = 1'b1; end
         MODE_BYP_INT: begin c.iref_on = 1'b1; c.loop_run = 1'b1; c.pick_ref = 1'b1; end
         MODE_BYP_LP:  begin c.iref_on = 1'b1; c.pick_ref = 1'b1; end
         default:      begin c.iref_on = 1'b1; c.loop_run = 1'b1; end
      endcase
      return c;
   endfunction

   function automatic cms_mode_e next_mode(input cms_mode_e cur,
                                           input logic [1:0] sel,
                                           input logic use_int,
                                           input logic lp,
                                           input logic dbg);
      cms_mode_e n;
      n = cur;
      if (sel == 2'b00)
         n = use_int ? MODE_INT_ENG : MODE_EXT_ENG;
      else if (sel == 2'b01 && use_int)
         n = (dbg || !lp) ? MODE_BYP_INT : MODE_BYP_LP;
      return n;
   endfunction

endpackage

// File: rtl/cms_sync.sv
`timescale 1ns/1ps
module cms_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_depth
      $error("cms_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/cms_range_chk.sv
`timescale 1ns/1ps
module cms_range_chk
   import cms_pkg::*;
#(
   parameter longint unsigned EXT_HZ      = 64'd1048576,
   parameter int              DIV_W       = 3,
   parameter int              RANGE_SHIFT = 5
) (
   input  logic [DIV_W-1:0] div_code,
   input  logic             range_hi,
   output logic             bad_div
);
   localparam int MAX_SHIFT = (1 << DIV_W) - 1 + RANGE_SHIFT;

   if (DIV_W < 1 || DIV_W > 4) begin : g_bad_w
      $error("cms_range_chk: DIV_W must be 1..4");
   end
   if (MAX_SHIFT > 40) begin : g_bad_shift
      $error("cms_range_chk: divider exponent too large");
   end
   if (EXT_HZ == 0) begin : g_bad_hz
      $error("cms_range_chk: EXT_HZ must be nonzero");
   end

   logic [7:0]  shamt;
   logic [63:0] lo_lim, hi_lim, f_x2;

   always_comb begin
      shamt  = 8'(div_code) + (range_hi ? 8'(RANGE_SHIFT) : 8'd0);
      lo_lim = WIN_LO_X2 << shamt;
      hi_lim = WIN_HI_X2 << shamt;
      f_x2   = EXT_HZ * 64'd2;
      bad_div = (f_x2 < lo_lim) || (f_x2 > hi_lim);
   end
endmodule

// File: rtl/cms_mode_fsm.sv
`timescale 1ns/1ps
module cms_mode_fsm
   import cms_pkg::*;
(
   input  logic       clk_cfg,
   input  logic       rst_n,
   input  logic [1:0] clk_sel,
   input  logic       ref_int,
   input  logic       low_pwr,
   input  logic       dbg_on,
   input  logic       bad_div,
   output cms_mode_e  mode_q,
   output logic       range_err
);
   cms_mode_e mode_d;

   always_comb mode_d = next_mode(mode_q, clk_sel, ref_int, low_pwr, dbg_on);

   always_ff @(posedge clk_cfg or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= MODE_INT_ENG;
         range_err <= 1'b0;
      end else begin
         mode_q    <= mode_d;
         range_err <= (mode_d == MODE_EXT_ENG) && bad_div;
      end
   end

   // R6
   dbg_wake_chk: assert property (@(posedge clk_cfg) disable iff (!rst_n)
      (mode_q == MODE_BYP_LP && dbg_on && clk_sel == 2'b01 && ref_int)
      |=> (mode_q == MODE_BYP_INT));

   // R7
   hold_chk: assert property (@(posedge clk_cfg) disable iff (!rst_n)
      (clk_sel[1] || (clk_sel == 2'b01 && !ref_int)) |=> $stable(mode_q));

   // R8
   range_mode_chk: assert property (@(posedge clk_cfg) disable iff (!rst_n)
      range_err |-> (mode_q == MODE_EXT_ENG));
endmodule

// File: rtl/cms_gfmux.sv
`timescale 1ns/1ps
module cms_gfmux #(
   parameter int STAGES = 2
) (
   input  logic clk_cfg,
   input  logic rst_n,
   input  logic pick_ref,
   input  logic clk_loop,
   input  logic clk_ref,
   output logic clk_out,
   output logic busy
);
   localparam int NSRC = 2;

   logic [NSRC-1:0] clks;
   logic [NSRC-1:0] want;
   logic [NSRC-1:0] gate;
   logic [NSRC-1:0] gate_cfg;

   assign clks = {clk_ref, clk_loop};
   assign want = {pick_ref, ~pick_ref};

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      logic req, armed, g_q;

      // A source may arm only once the other one has been released.
      assign req = want[i] & ~gate[NSRC-1-i];

      cms_sync #(.STAGES(STAGES)) u_arm (
         .clk   (clks[i]),
         .rst_n (rst_n),
         .d     (req),
         .q     (armed)
      );

      // Gate changes while this source is low, so no runt pulse reaches the OR.
      always_ff @(negedge clks[i] or negedge rst_n) begin
         if (!rst_n) g_q <= 1'b0;
         else        g_q <= armed;
      end
      assign gate[i] = g_q;

      cms_sync #(.STAGES(STAGES)) u_back (
         .clk   (clk_cfg),
         .rst_n (rst_n),
         .d     (g_q),
         .q     (gate_cfg[i])
      );
   end

   assign clk_out = |(clks & gate);
   assign busy    = pick_ref ? ~(gate_cfg[1] & ~gate_cfg[0])
                             : ~(gate_cfg[0] & ~gate_cfg[1]);

   // R10
   gate_excl_chk: assert property (@(posedge clk_cfg) disable iff (!rst_n)
      !(gate[0] && gate[1]));
endmodule

// File: rtl/clk_mode_ctrl.sv
`timescale 1ns/1ps
module clk_mode_ctrl
   import cms_pkg::*;
#(
   parameter longint unsigned EXT_HZ      = 64'd1048576,
   parameter int              DIV_W       = 3,
   parameter int              RANGE_SHIFT = 5,
   parameter int              SYNC_STAGES = 2
) (
   input  logic             clk_cfg,
   input  logic             rst_n,
   input  logic [1:0]       clk_sel,
   input  logic             ref_int,
   input  logic             low_pwr,
   input  logic             dbg_on,
   input  logic [DIV_W-1:0] div_code,
   input  logic             range_hi,
   input  logic             clk_loop,
   input  logic             clk_iref,
   output logic             iref_en,
   output logic             eref_en,
   output logic             loop_en,
   output logic             loop_ref_ext,
   output logic             range_err,
   output logic [2:0]       mode,
   output logic             busy
   ,output logic            clk_out
);
   cms_mode_e mode_q;
   cms_ctl_t  ctl;
   logic      bad_div;

   cms_range_chk #(
      .EXT_HZ      (EXT_HZ),
      .DIV_W       (DIV_W),
      .RANGE_SHIFT (RANGE_SHIFT)
   ) u_range (
      .div_code (div_code),
      .range_hi (range_hi),
      .bad_div  (bad_div)
   );

   cms_mode_fsm u_fsm (
      .clk_cfg   (clk_cfg),
      .rst_n     (rst_n),
      .clk_sel   (clk_sel),
      .ref_int   (ref_int),
      .low_pwr   (low_pwr),
      .dbg_on    (dbg_on),
      .bad_div   (bad_div),
      .mode_q    (mode_q),
      .range_err (range_err)
   );

   assign ctl = ctl_of(mode_q);

   cms_gfmux #(.STAGES(SYNC_STAGES)) u_mux (
      .clk_cfg  (clk_cfg),
      .rst_n    (rst_n),
      .pick_ref (ctl.pick_ref),
      .clk_loop (clk_loop),
      .clk_ref  (clk_iref),
      .clk_out  (clk_out),
      .busy     (busy)
   );

   assign iref_en      = ctl.iref_on;
   assign eref_en      = ctl.eref_on;
   assign loop_ref_ext = ctl.loop_ext;
   // The loop is held up until the multiplexer has let go of it.
   assign loop_en      = ctl.loop_run | busy;
   assign mode         = mode_q;

   // R5
   loop_off_chk: assert property (@(posedge clk_cfg) disable iff (!rst_n)
      !loop_en |-> (mode == 3'd3 && !busy));

   // R3
   eref_only_chk: assert property (@(posedge clk_cfg) disable iff (!rst_n)
      eref_en |-> (mode == 3'd1 && !iref_en));

   // R2
   int_ref_chk: assert property (@(posedge clk_cfg) disable iff (!rst_n)
      (mode != 3'd1) |-> (iref_en && !loop_ref_ext));
endmodule

// File: tb/clk_mode_ctrl_bench.sv
`timescale 1ns/1ps
module clk_mode_ctrl_bench;
   localparam real EXT_F = 1048576.0;

   logic       clk_cfg = 1'b0;
   logic       clk_loop = 1'b0;
   logic       clk_iref = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] clk_sel = 2'b00;
   logic       ref_int = 1'b1;
   logic       low_pwr = 1'b0;
   logic       dbg_on = 1'b0;
   logic [2:0] div_code = 3'd5;
   logic       range_hi = 1'b0;
   logic       iref_en, eref_en, loop_en, loop_ref_ext, range_err, busy, clk_out;
   logic [2:0] mode;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;
   int out_edges = 0;
   int glitches = 0;
   bit mon_on = 0;
   realtime last_t = 0.0;

   always #4  clk_cfg  = ~clk_cfg;
   always #3  clk_loop = ~clk_loop;
   always #20 clk_iref = ~clk_iref;

   clk_mode_ctrl u_clk_mode_ctrl (
      .clk_cfg(clk_cfg), .rst_n(rst_n), .clk_sel(clk_sel), .ref_int(ref_int),
      .low_pwr(low_pwr), .dbg_on(dbg_on), .div_code(div_code), .range_hi(range_hi),
      .clk_loop(clk_loop), .clk_iref(clk_iref), .iref_en(iref_en), .eref_en(eref_en),
      .loop_en(loop_en), .loop_ref_ext(loop_ref_ext), .range_err(range_err),
      .mode(mode), .busy(busy), .clk_out(clk_out)
   );

   always @(posedge clk_out) out_edges++;

   always @(clk_out) begin
      if (mon_on && ($realtime - last_t) < 2.9) glitches++;
      last_t = $realtime;
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk_cfg);
      @(negedge clk_cfg);
   endtask

   task automatic apply(input logic [1:0] s, input logic ri, input logic lp, input logic dg);
      clk_sel = s; ref_int = ri; low_pwr = lp; dbg_on = dg;
      step();
   endtask

   task automatic wait_idle(input string req);
      int k;
      k = 0;
      while (busy && k < 300) begin step(); k++; end
      chk(req, "busy clears", int'(busy), 0);
   endtask

   task automatic chk_set(input string req, input int m, input int ir, input int er,
                          input int le, input int lx);
      chk(req, "mode", int'(mode), m);
      chk(req, "iref_en", int'(iref_en), ir);
      chk(req, "eref_en", int'(eref_en), er);
      chk(req, "loop_en", int'(loop_en), le);
      chk(req, "loop_ref_ext", int'(loop_ref_ext), lx);
   endtask

   task automatic count_out(input string req, input int exp);
      int n0, d;
      n0 = out_edges;
      #1200;
      d = out_edges - n0;
      chk(req, "clk_out edges in window", (d >= exp - 2 && d <= exp + 2) ? exp : d, exp);
      @(negedge clk_cfg);
   endtask

   task automatic t_reset();
      #2;
      chk_set("R1", 0, 1, 0, 1, 0);
      chk("R1", "range_err in reset", int'(range_err), 0);
      #30 @(negedge clk_cfg);
      rst_n = 1'b1;
      mon_on = 1;
      step();
      chk_set("R1", 0, 1, 0, 1, 0);
      wait_idle("R1");
   endtask

   task automatic t_int_eng();
      apply(2'b00, 1'b1, 1'b0, 1'b0);
      chk_set("R2", 0, 1, 0, 1, 0);
      count_out("R9", 200);
   endtask

   task automatic t_ext_eng();
      div_code = 3'd5; range_hi = 1'b0;
      apply(2'b00, 1'b0, 1'b0, 1'b0);
      chk_set("R3", 1, 0, 1, 1, 1);
      count_out("R9", 200);
   endtask

   task automatic t_hold();
      apply(2'b10, 1'b1, 1'b1, 1'b0);
      chk_set("R7", 1, 0, 1, 1, 1);
      apply(2'b11, 1'b0, 1'b0, 1'b1);
      chk_set("R7", 1, 0, 1, 1, 1);
      apply(2'b01, 1'b0, 1'b1, 1'b0);
      chk_set("R7", 1, 0, 1, 1, 1);
   endtask

   function automatic int exp_err(input int dc, input int hi);
      real f;
      f = EXT_F / (2.0 ** (dc + 5 * hi));
      return (f < 31250.0 || f > 39062.5) ? 1 : 0;
   endfunction

   task automatic t_range();
      int cases [5][2] = '{'{5,0}, '{4,0}, '{6,0}, '{0,1}, '{1,1}};
      apply(2'b00, 1'b0, 1'b0, 1'b0);
      foreach (cases[i]) begin
         div_code = 3'(cases[i][0]); range_hi = cases[i][1][0];
         step();
         chk("R8", $sformatf("range_err div %0d hi %0d", cases[i][0], cases[i][1]),
             int'(range_err), exp_err(cases[i][0], cases[i][1]));
      end
      div_code = 3'd4; range_hi = 1'b0;
      apply(2'b00, 1'b1, 1'b0, 1'b0);
      chk("R8", "range_err outside external mode", int'(range_err), 0);
      div_code = 3'd5;
   endtask

   task automatic t_bypass();
      apply(2'b01, 1'b1, 1'b0, 1'b0);
      chk_set("R4", 2, 1, 0, 1, 0);
      chk("R10", "busy on switch to reference", int'(busy), 1);
      wait_idle("R10");
      count_out("R9", 30);
      apply(2'b01, 1'b1, 1'b1, 1'b1);
      chk_set("R4", 2, 1, 0, 1, 0);
   endtask

   task automatic t_low_power();
      apply(2'b01, 1'b1, 1'b1, 1'b0);
      chk_set("R5", 3, 1, 0, 0, 0);
      chk("R5", "no switch from bypass", int'(busy), 0);
      count_out("R9", 30);
      apply(2'b00, 1'b1, 1'b0, 1'b0);
      wait_idle("R10");
      apply(2'b01, 1'b1, 1'b1, 1'b0);
      chk("R5", "mode on entry from engaged", int'(mode), 3);
      chk("R5", "loop held during switch", int'(loop_en), 1);
      wait_idle("R5");
      chk("R5", "loop off after switch", int'(loop_en), 0);
   endtask

   task automatic t_dbg_wake();
      dbg_on = 1'b1;
      step();
      chk_set("R6", 2, 1, 0, 1, 0);
      dbg_on = 1'b0;
      step();
      chk("R6", "back to low power", int'(mode), 3);
   endtask

   task automatic t_glitch();
      apply(2'b00, 1'b1, 1'b0, 1'b0);
      wait_idle("R10");
      count_out("R9", 200);
      chk("R10", "short clk_out phases", glitches, 0);
   endtask

   initial begin
      t_reset();
      t_int_eng();
      t_ext_eng();
      t_hold();
      t_range();
      t_bypass();
      t_low_power();
      t_dbg_wake();
      t_glitch();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule